// File: doc/BRIEF.md
# Snooping Write-Back Line Controller

This block tracks the coherency state of a small, direct-mapped set of cache lines and answers snoops from other bus masters. Each snoop carries a line address and an invalidate qualifier. A snoop that finds a line holding dirty data raises a hit-dirty indication and copies the whole line out to memory as a burst. A snoop that finds clean data, or finds nothing, needs no bus traffic.

The same lines are loaded by a core-side install port, which writes a tag, a state and a full line of data. The install port is held off while a copy-out is scheduled or running, so the dirty line reaches memory before any core work proceeds. The copy-out follows a simple bus handshake. The memory side can end beats with a burst-ready or a plain-ready. It can also force a back-off, which abandons the current attempt and restarts it once the back-off is lifted.

Top module: `snoopwb_ctrl`

## Requirements
- R1: Each line holds a tag and a 2-bit state, encoded 00 invalid, 01 shared, 10 exclusive, 11 modified. When `core_gnt` is high in a cycle, the line indexed by the low address bits takes the tag, state and data presented on the install port at the next clock edge.
- R2: A snoop is sampled on a clock edge where `snoop_valid` is high and no copy-out is in progress. `snoop_hit` is high for exactly the following cycle when the addressed line has a matching tag and a state other than invalid.
- R3: A sampled snoop that hits sets the line to invalid when `snoop_inv` is 1 and to shared when it is 0.
- R4: A sampled snoop that hits a modified line raises `snoop_hitm` in the following cycle. It stays high until the copy-out completes. A miss or a clean hit leaves `snoop_hitm` low and produces no `bus_start`.
- R5: A copy-out starts with `bus_start` in the first cycle `snoop_hitm` is high, at word offset 0 (the low two bits of `bus_addr`). It then sends the four words in ascending order, one per data cycle, with `bus_last` high on word 3. It completes on a data cycle where `bus_last` and `bus_brdy` are high, and `snoop_hitm` drops the next cycle.
- R6: While `snoop_hitm` is high, `snoop_valid` is ignored. No hit is reported and no line state changes.
- R7: `core_gnt` is high only when `core_req` is high, no copy-out is in progress and `snoop_valid` is low. A write-back pending at the same time as a core request goes first.
- R8: `bus_boff` high in an address or data cycle abandons the attempt and discards that cycle's handshake. After `bus_boff` returns low, `bus_start` is raised one clock later, and the copy-out repeats in burst mode from word 0.
- R9: A data cycle ended by `bus_rdy` without `bus_brdy` ends burst mode. Each remaining word goes out as its own single transfer with its own `bus_start` and with `bus_last` high.
- R10: Reset makes every line invalid and drives `snoop_hit`, `snoop_hitm`, `bus_start` and `bus_last` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snoop_valid | input | 1 | Snoop strobe |
| snoop_addr | input | 10 | Snooped line address: tag above, line index in the low 2 bits |
| snoop_inv | input | 1 | 1: snoop from a write, invalidate on hit |
| snoop_hit | output | 1 | One-cycle pulse: sampled snoop hit a valid line |
| snoop_hitm | output | 1 | Snoop hit dirty data; copy-out pending or in progress |
| core_req | input | 1 | Install request, held until granted |
| core_addr | input | 10 | Line address to install |
| core_state | input | 2 | State to install |
| core_data | input | 128 | Line data, word 0 in the low bits |
| core_gnt | output | 1 | Install accepted at this clock edge |
| bus_start | output | 1 | Address strobe of a write transfer |
| bus_addr | output | 12 | Word address of the current beat |
| bus_data | output | 32 | Write data in data cycles |
| bus_last | output | 1 | Current beat is the final one of the transfer |
| bus_brdy | input | 1 | Burst-ready: beat accepted, burst continues |
| bus_rdy | input | 1 | Plain-ready: beat accepted, burst ends |
| bus_boff | input | 1 | Back-off: abandon current attempt |

## Verification
The in-line assertions check the following on every cycle:
- snoops arriving during a copy-out never produce a hit;
- a grant never coincides with a copy-out or a snoop strobe;
- every copy-out opens at offset 0;
- the hit-dirty flag only falls after a final accepted beat;
- a lifted back-off is followed by a start one clock later;
- a plain-ready mid-burst turns the next transfer into a single-beat one.

Only the scenarios can show the rest:
- that line states really move to shared or invalid, seen through later snoops;
- that a snoop ignored during a copy-out left its line dirty;
- that the words come out in order with the right data;
- the exact cycle counts of clean, backed-off and single-transfer copy-outs.

// File: rtl/snoopwb_pkg.sv
package snoopwb_pkg;

    // Line coherency state, bit 1 and bit 0 stored per line
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } lstate_e;

    // Copy-out sequencer phases
    typedef enum logic [1:0] {
        WB_IDLE = 2'b00,
        WB_ADDR = 2'b01,
        WB_DATA = 2'b10,
        WB_HOLD = 2'b11
    } wbst_e;

endpackage

// File: rtl/snoopwb_line_store.sv
module snoopwb_line_store
    import snoopwb_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 8,
    parameter int LINE_W = 128,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_en,
    input  logic [IDX_W-1:0]        upd_idx,
    input  lstate_e                 upd_state,
    input  logic                    ins_en,
    input  logic [IDX_W-1:0]        ins_idx,
    input  logic [TAG_W-1:0]        ins_tag,
    input  lstate_e                 ins_state,
    input  logic [LINE_W-1:0]       ins_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LINE_W-1:0]       rd_data,
    output logic [LINES*TAG_W-1:0]  tag_vec,
    output logic [LINES*2-1:0]      st_vec
);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        lstate_e           st;
        logic [LINE_W-1:0] data;
    } entry_t;

    typedef struct packed {
        entry_t [LINES-1:0] ent;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < LINES; i++) begin
            if (upd_en && (upd_idx == IDX_W'(i))) begin
                s_d.ent[i].st = upd_state;
            end
            if (ins_en && (ins_idx == IDX_W'(i))) begin
                s_d.ent[i].tag  = ins_tag;
                s_d.ent[i].st   = ins_state;
                s_d.ent[i].data = ins_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.ent[rd_idx].data;

    for (genvar g = 0; g < LINES; g++) begin : g_view
        assign tag_vec[g*TAG_W +: TAG_W] = s_q.ent[g].tag;
        assign st_vec[g*2 +: 2]          = s_q.ent[g].st;
    end

    // R7: a snoop update and a core install never target the store together
    assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_en && ins_en));

endmodule

// File: rtl/snoopwb_lookup.sv
module snoopwb_lookup
    import snoopwb_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES*TAG_W-1:0] tag_vec,
    input  logic [LINES*2-1:0]     st_vec,
    input  logic [IDX_W-1:0]       look_idx,
    input  logic [TAG_W-1:0]       look_tag,
    output logic                   hit,
    output logic                   hit_mod
);

    logic [LINES-1:0] match;
    logic [LINES-1:0] match_mod;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        logic [1:0] st_g;
        assign st_g = st_vec[g*2 +: 2];
        assign match[g] = (look_idx == IDX_W'(g))
                        && (tag_vec[g*TAG_W +: TAG_W] == look_tag)
                        && (st_g != LS_INV);
        assign match_mod[g] = match[g] && (st_g == LS_MOD);
    end

    assign hit     = |match;
    assign hit_mod = |match_mod;

endmodule

// File: rtl/snoopwb_seq.sv
module snoopwb_seq
    import snoopwb_pkg::*;
#(
    parameter int LA_W   = 10,
    parameter int WORD_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int LINE_W = WORD_W * BEATS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  logic [LA_W-1:0]        launch_addr,
    input  logic [LINE_W-1:0]      launch_data,
    input  logic                   brdy,
    input  logic                   rdy,
    input  logic                   boff,
    output logic                   busy,
    output logic                   start,
    output logic [LA_W+BEAT_W-1:0] addr,
    output logic [WORD_W-1:0]      data,
    output logic                   last
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        wbst_e             st;
        logic [BEAT_W-1:0] beat;
        logic              single;
        logic [LA_W-1:0]   base;
        logic [LINE_W-1:0] line_buf;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WB_IDLE: begin
                if (launch) begin
                    r_d.st       = WB_ADDR;
                    r_d.beat     = '0;
                    r_d.single   = 1'b0;
                    r_d.base     = launch_addr;
                    r_d.line_buf = launch_data;
                end
            end
            WB_ADDR: begin
                if (boff) begin
                    r_d.st     = WB_HOLD;
                    r_d.beat   = '0;
                    r_d.single = 1'b0;
                end else begin
                    r_d.st = WB_DATA;
                end
            end
            WB_DATA: begin
                if (boff) begin
                    r_d.st     = WB_HOLD;
                    r_d.beat   = '0;
                    r_d.single = 1'b0;
                end else if (brdy && !r_q.single) begin
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.st = WB_IDLE;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                    end
                end else if (brdy || rdy) begin
                    r_d.single = 1'b1;
                    if (r_q.beat == LAST_BEAT) begin
                        r_d.st = WB_IDLE;
                    end else begin
                        r_d.beat = r_q.beat + 1'b1;
                        r_d.st   = WB_ADDR;
                    end
                end
            end
            WB_HOLD: begin
                if (!boff) begin
                    r_d.st = WB_ADDR;
                end
            end
            default: r_d.st = WB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic active;
    assign busy   = (r_q.st != WB_IDLE);
    assign start  = (r_q.st == WB_ADDR);
    assign active = start || (r_q.st == WB_DATA);
    assign addr   = active ? {r_q.base, r_q.beat} : '0;
    assign data   = (r_q.st == WB_DATA) ? r_q.line_buf[int'(r_q.beat)*WORD_W +: WORD_W] : '0;
    assign last   = active && (r_q.single || (r_q.beat == LAST_BEAT));

    // R9: plain-ready on a non-final burst beat turns the next transfer single
    assert_rdy_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WB_DATA && rdy && !brdy && !boff && r_q.beat != LAST_BEAT)
        |=> (start && last));

    // R5: final beat accepted with burst-ready ends the copy-out
    assert_final_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == WB_DATA && last && brdy && !boff && r_q.beat == LAST_BEAT)
        |=> !busy);

    // R8: back-off in an active phase leaves the bus idle the next cycle
    assert_boff_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && boff) |=> (!start && !last && busy));

endmodule

// File: rtl/snoopwb_ctrl.sv
module snoopwb_ctrl
    import snoopwb_pkg::*;
#(
    parameter int LINES       = 4,
    parameter int LINE_ADDR_W = 10,
    parameter int WORD_W      = 32,
    parameter int BEATS       = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     snoop_valid,
    input  logic [LINE_ADDR_W-1:0]                   snoop_addr,
    input  logic                                     snoop_inv,
    output logic                                     snoop_hit,
    output logic                                     snoop_hitm,
    input  logic                                     core_req,
    input  logic [LINE_ADDR_W-1:0]                   core_addr,
    input  logic [1:0]                               core_state,
    input  logic [WORD_W*BEATS-1:0]                  core_data,
    output logic                                     core_gnt,
    output logic                                     bus_start,
    output logic [LINE_ADDR_W+$clog2(BEATS)-1:0]     bus_addr,
    output logic [WORD_W-1:0]                        bus_data,
    output logic                                     bus_last,
    input  logic                                     bus_brdy,
    input  logic                                     bus_rdy,
    input  logic                                     bus_boff
);

    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = LINE_ADDR_W - IDX_W;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int LINE_W = WORD_W * BEATS;

    typedef struct packed {
        logic hit;
    } top_t;

    top_t t_d, t_q;

    logic [LINES*TAG_W-1:0] tag_vec;
    logic [LINES*2-1:0]     st_vec;
    logic [LINE_W-1:0]      rd_data;
    logic                   look_hit, look_mod;
    logic                   busy, take;
    logic [IDX_W-1:0]       s_idx;
    logic [TAG_W-1:0]       s_tag;
    lstate_e                new_state;

    assign s_idx     = snoop_addr[IDX_W-1:0];
    assign s_tag     = snoop_addr[LINE_ADDR_W-1:IDX_W];
    assign take      = snoop_valid && !busy;
    assign new_state = snoop_inv ? LS_INV : LS_SHR;
    assign core_gnt  = core_req && !busy && !snoop_valid;

    snoopwb_lookup #(.LINES(LINES), .TAG_W(TAG_W)) u_lookup (
        .tag_vec  (tag_vec),
        .st_vec   (st_vec),
        .look_idx (s_idx),
        .look_tag (s_tag),
        .hit      (look_hit),
        .hit_mod  (look_mod)
    );

    snoopwb_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (take && look_hit),
        .upd_idx   (s_idx),
        .upd_state (new_state),
        .ins_en    (core_gnt),
        .ins_idx   (core_addr[IDX_W-1:0]),
        .ins_tag   (core_addr[LINE_ADDR_W-1:IDX_W]),
        .ins_state (lstate_e'(core_state)),
        .ins_data  (core_data),
        .rd_idx    (s_idx),
        .rd_data   (rd_data),
        .tag_vec   (tag_vec),
        .st_vec    (st_vec)
    );

    snoopwb_seq #(.LA_W(LINE_ADDR_W), .WORD_W(WORD_W), .BEATS(BEATS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (take && look_mod),
        .launch_addr (snoop_addr),
        .launch_data (rd_data),
        .brdy        (bus_brdy),
        .rdy         (bus_rdy),
        .boff        (bus_boff),
        .busy        (busy),
        .start       (bus_start),
        .addr        (bus_addr),
        .data        (bus_data),
        .last        (bus_last)
    );

    always_comb begin
        t_d     = t_q;
        t_d.hit = take && look_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign snoop_hit  = t_q.hit;
    assign snoop_hitm = busy;

    // R6: a strobe during a copy-out is not sampled
    assert_snoop_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_hitm && snoop_valid) |=> !snoop_hit);

    // R7: installs wait for the copy-out and for any snoop strobe
    assert_gnt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_gnt |-> (!snoop_hitm && !snoop_valid));

    // R5: every copy-out opens with an address strobe at offset 0
    assert_open_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snoop_hitm) |-> (bus_start && bus_addr[BEAT_W-1:0] == '0));

    // R5: the hit-dirty flag drops only after an accepted final beat
    assert_hitm_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(snoop_hitm) |-> $past(bus_last && (bus_brdy || bus_rdy) && !bus_boff));

    // R4: no bus activity without a dirty hit
    assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_hitm |-> (!bus_start && !bus_last));

    // R8: the address strobe returns one clock after back-off is lifted
    assert_boff_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_boff && $past(bus_boff) && $past(snoop_hitm) && snoop_hitm) |=> bus_start);

endmodule

// File: tb/snoopwb_ctrl_tb.sv
module snoopwb_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snoop_valid = 1'b0;
    logic [9:0] snoop_addr = '0;
    logic snoop_inv = 1'b0;
    logic snoop_hit, snoop_hitm;
    logic core_req = 1'b0;
    logic [9:0] core_addr = '0;
    logic [1:0] core_state = '0;
    logic [127:0] core_data = '0;
    logic core_gnt;
    logic bus_start;
    logic [11:0] bus_addr;
    logic [31:0] bus_data;
    logic bus_last;
    logic bus_brdy = 1'b0;
    logic bus_rdy = 1'b0;
    logic bus_boff = 1'b0;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    snoopwb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_inv(snoop_inv),
        .snoop_hit(snoop_hit), .snoop_hitm(snoop_hitm),
        .core_req(core_req), .core_addr(core_addr), .core_state(core_state),
        .core_data(core_data), .core_gnt(core_gnt),
        .bus_start(bus_start), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_last(bus_last), .bus_brdy(bus_brdy), .bus_rdy(bus_rdy), .bus_boff(bus_boff)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int           m_st[4];
    logic [7:0]   m_tag[4];
    logic [127:0] m_data[4];
    int           ms = 0;      // 0 idle, 1 address, 2 data, 3 held off
    int           mbeat = 0;
    bit           msingle = 0;
    bit           mhit = 0;
    logic [9:0]   mbase = '0;
    logic [127:0] mbuf = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
            ms = 0; mbeat = 0; msingle = 0; mhit = 0;
        end else begin
            bit nh;
            nh = 0;
            if (ms == 0) begin
                if (snoop_valid) begin
                    int ix;
                    ix = int'(snoop_addr[1:0]);
                    if (m_st[ix] != 0 && m_tag[ix] == snoop_addr[9:2]) begin
                        nh = 1;
                        if (m_st[ix] == 3) begin
                            mbuf = m_data[ix]; mbase = snoop_addr;
                            ms = 1; mbeat = 0; msingle = 0;
                        end
                        m_st[ix] = snoop_inv ? 0 : 1;
                    end
                end else if (core_req) begin
                    int jx;
                    jx = int'(core_addr[1:0]);
                    m_st[jx] = int'(core_state); m_tag[jx] = core_addr[9:2]; m_data[jx] = core_data;
                end
            end else if (ms == 1) begin
                if (bus_boff) begin ms = 3; mbeat = 0; msingle = 0; end
                else ms = 2;
            end else if (ms == 2) begin
                if (bus_boff) begin ms = 3; mbeat = 0; msingle = 0; end
                else if (bus_brdy && !msingle) begin
                    if (mbeat == 3) ms = 0; else mbeat++;
                end else if (bus_brdy || bus_rdy) begin
                    msingle = 1;
                    if (mbeat == 3) ms = 0; else begin mbeat++; ms = 1; end
                end
            end else begin
                if (!bus_boff) ms = 1;
            end
            mhit = nh;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit act;
            act = (ms == 1 || ms == 2);
            chk("R2 snoop_hit", 128'(snoop_hit), 128'(mhit));
            chk("R4 snoop_hitm", 128'(snoop_hitm), 128'(ms != 0));
            chk("R5 bus_start", 128'(bus_start), 128'(ms == 1));
            chk("R5 bus_addr", 128'(bus_addr), act ? 128'({mbase, 2'(mbeat)}) : 128'(0));
            chk("R5 bus_data", 128'(bus_data), (ms == 2) ? 128'(mbuf[mbeat*32 +: 32]) : 128'(0));
            chk("R9 bus_last", 128'(bus_last), 128'(act && (msingle || mbeat == 3)));
            chk("R7 core_gnt", 128'(core_gnt), 128'(core_req && ms == 0 && !snoop_valid));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [127:0] line_of(input int k);
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[i*32 +: 32] = 32'((k << 8) | (i + 1));
        return v;
    endfunction

    task automatic snoop(input logic [9:0] a, input bit inv, output bit h, output bit hm);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a; snoop_inv = inv;
        @(negedge clk);
        snoop_valid = 1'b0;
        #2;
        h = snoop_hit; hm = snoop_hitm;
    endtask

    task automatic install(input logic [9:0] a, input logic [1:0] st, input logic [127:0] d);
        @(negedge clk);
        core_req = 1'b1; core_addr = a; core_state = st; core_data = d;
        #2;
        while (!core_gnt) begin @(negedge clk); #2; end
        @(negedge clk);
        core_req = 1'b0;
    endtask

    task automatic run_wb(input int boff_at, input int boff_len, output int cyc, output int starts);
        cyc = 0; starts = 0;
        while (snoop_hitm === 1'b1 && cyc < 200) begin
            if (bus_start) starts++;
            cyc++;
            @(negedge clk);
            bus_boff = (cyc >= boff_at && cyc < boff_at + boff_len);
            #2;
        end
        bus_boff = 1'b0;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    localparam logic [9:0] LA = {8'h21, 2'd0};
    localparam logic [9:0] LB = {8'h35, 2'd1};
    localparam logic [9:0] LC = {8'h4A, 2'd2};
    localparam logic [9:0] LD = {8'h5C, 2'd3};
    localparam logic [9:0] LE = {8'h66, 2'd0};

    initial begin
        bit h, hm;
        int cyc, starts;
        repeat (3) @(negedge clk);
        #2;
        chk("R10 hitm in reset", 128'(snoop_hitm), 128'(0));
        chk("R10 start in reset", 128'(bus_start), 128'(0));
        chk("R10 last in reset", 128'(bus_last), 128'(0));
        @(negedge clk); rst_n = 1'b1;

        snoop(LA, 0, h, hm);
        chk("R10 lines invalid after reset", 128'(h), 128'(0));

        install(LA, 2'b10, line_of(1));
        snoop({8'h22, 2'd0}, 0, h, hm);
        chk("R2 tag mismatch misses", 128'(h), 128'(0));
        snoop(LA, 0, h, hm);
        chk("R2 exclusive hit", 128'(h), 128'(1));
        chk("R4 clean hit no hitm", 128'(hm), 128'(0));
        snoop(LA, 0, h, hm);
        chk("R3 shared after read snoop", 128'(h), 128'(1));
        snoop(LA, 1, h, hm);
        snoop(LA, 0, h, hm);
        chk("R3 invalid after write snoop", 128'(h), 128'(0));

        // clean burst copy-out
        bus_brdy = 1'b1;
        install(LB, 2'b11, line_of(2));
        snoop(LB, 0, h, hm);
        chk("R4 dirty hit raises hitm", 128'(hm), 128'(1));
        run_wb(1000, 0, cyc, starts);
        chk("R5 burst cycles", 128'(cyc), 128'(5));
        chk("R5 burst starts", 128'(starts), 128'(1));
        snoop(LB, 0, h, hm);
        chk("R3 shared after dirty read snoop", 128'(h), 128'(1));
        chk("R3 shared line no hitm", 128'(hm), 128'(0));

        // back-off in the middle of a burst
        install(LB, 2'b11, line_of(3));
        snoop(LB, 0, h, hm);
        run_wb(3, 2, cyc, starts);
        chk("R8 backed-off cycles", 128'(cyc), 128'(11));
        chk("R8 backed-off starts", 128'(starts), 128'(2));

        // snoop and install arriving during a copy-out
        install(LD, 2'b11, line_of(4));
        install(LC, 2'b11, line_of(5));
        snoop(LC, 1, h, hm);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = LD; snoop_inv = 1'b1;
        core_req = 1'b1; core_addr = LE; core_state = 2'b10; core_data = line_of(6);
        #2;
        chk("R7 install held during copy-out", 128'(core_gnt), 128'(0));
        @(negedge clk);
        snoop_valid = 1'b0;
        #2;
        chk("R6 snoop ignored while busy", 128'(snoop_hit), 128'(0));
        run_wb(1000, 0, cyc, starts);
        chk("R7 install granted after copy-out", 128'(core_gnt), 128'(1));
        @(negedge clk);
        core_req = 1'b0;

        // plain-ready copy-out of the line whose snoop was ignored
        bus_brdy = 1'b0; bus_rdy = 1'b1;
        snoop(LD, 1, h, hm);
        chk("R6 ignored snoop left line dirty", 128'(hm), 128'(1));
        run_wb(1000, 0, cyc, starts);
        chk("R9 single-transfer cycles", 128'(cyc), 128'(8));
        chk("R9 single-transfer starts", 128'(starts), 128'(4));
        bus_rdy = 1'b0;

        snoop(LC, 0, h, hm);
        chk("R3 invalid after dirty write snoop", 128'(h), 128'(0));
        snoop(LE, 0, h, hm);
        chk("R1 installed line hits", 128'(h), 128'(1));
        chk("R1 exclusive install is clean", 128'(hm), 128'(0));
        snoop(LA, 0, h, hm);
        chk("R1 replaced line misses", 128'(h), 128'(0));

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule